// File: doc/BRIEF.md
# Serial Bus Control and Acknowledge Unit

This block is the control and status logic that sits beside the shifter of a two-wire serial bus port. Software reaches it through a small write/read register port. Writing a 1 to one of three trigger fields does one of three things: it forces the serial output latch high to release the bus, it forces the latch low to signal a command, or it requests a manual acknowledge. The release and command triggers take effect at once and leave nothing set. The acknowledge request stays armed until it has been driven, and software cannot withdraw it. One read/write enable bit selects automatic acknowledge.

The unit watches the bus clock and data lines through two-stage synchronizers. A rise of data while the clock is high is a release condition. A fall of data while the clock is high is a command condition. Each condition sets its own sticky flag, and each flag has its own set of clear events. A frame counter is cleared by the transfer-start strobe and counts falling clock edges. The unit uses it to place an acknowledge in the ninth clock of a byte, or in the clock that follows a late enable or a manual trigger.

The data output is the latch value, except while an acknowledge is driven. During an acknowledge the output is held low for exactly one bus clock, and then the latch value shows again.

Top module: `sbus_ctl_unit`

## Requirements
- R1: After reset the data output `sda_out` is 1 and `reg_rdata` reads 0.
- R2: A register write with bit 3 (release trigger) set drives `sda_out` to 1 from the next cycle. If bits 3 and 2 are both set in one write, release wins and the output is 1.
- R3: A register write with only bit 2 (command trigger) set drives `sda_out` to 0. A later write with bits 3:2 at 0 leaves the latch unchanged.
- R4: A rise of `sda_in` while `scl_in` is high sets the release flag, read on `reg_rdata[3]`.
- R5: The release flag is cleared by `xfer_start`, by `addr_miss`, and while `port_en` is 0.
- R6: A fall of `sda_in` while `scl_in` is high sets the command flag (`reg_rdata[2]`). The command flag is cleared by a detected release condition, by `xfer_start`, and while `port_en` is 0.
- R7: Bit 0 of every write is stored as the automatic-acknowledge enable and reads back on `reg_rdata[0]`. `reg_rdata[1]` reads 0.
- R8: If the enable is 1 when the eighth falling clock edge after `xfer_start` occurs, `sda_out` is 0 throughout the high phase of the ninth clock. It is 1 (the latch value) during clocks 1 to 8 and after the ninth falling edge.
- R9: With the enable at 0, no clock of the nine-clock frame sees `sda_out` low.
- R10: If the enable is written from 0 to 1 after eight clocks have been counted and no acknowledge has yet been given in that frame, `sda_out` is low for the next bus clock only.
- R11: A write with bit 1 (manual acknowledge) after eight clocks drives `sda_out` low for the next bus clock only. The same write made before eight clocks have been counted is ignored.
- R12: While `port_en` is 0, a pending or active acknowledge is cancelled and `sda_out` shows the latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: [3] release trigger, [2] command trigger, [1] manual acknowledge, [0] acknowledge enable |
| reg_rdata | output | 4 | Read data: [3] release flag, [2] command flag, [1] zero, [0] acknowledge enable |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line (asynchronous) |
| xfer_start | input | 1 | Transfer-start strobe, one cycle |
| port_en | input | 1 | Port enable |
| addr_miss | input | 1 | Pulse: received address did not match |
| sda_out | output | 1 | Serial output latch with acknowledge override |

## Verification
The hardest cases to reach are the acknowledge paths that depend on when a write lands within the frame. These are the enable written late, after eight clocks, and the manual trigger written both too early and in time. The bench generates bus clocks slowly, about twenty system cycles per phase, and places each register write in the low phase after a chosen clock count. It then samples `sda_out` in the middle of each following high phase. Condition detection is reached by moving the data line only while the clock is high, and by bringing it back while the clock is low so that no other event is seen.

// File: rtl/sbus_ctl_pkg.sv
package sbus_ctl_pkg;

    localparam int BYTE_BITS  = 8;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic rel_trig;
        logic cmd_trig;
        logic ack_trig;
        logic ack_en;
    } ctl_wr_t;

    typedef struct packed {
        logic rel_seen;
        logic cmd_seen;
        logic zero;
        logic ack_en;
    } ctl_rd_t;

    typedef struct packed {
        logic rel_evt;
        logic cmd_evt;
        logic clk_fall;
        logic clk_lvl;
    } bus_evt_t;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_WAIT  = 2'd1,
        ACK_DRIVE = 2'd2
    } ack_state_t;

    function automatic logic latch_next(input logic cur, input logic wr, input ctl_wr_t w);
        logic nxt;
        nxt = cur;
        if (wr && w.rel_trig)      nxt = 1'b1;
        else if (wr && w.cmd_trig) nxt = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '1;
                    else     stg[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '1;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/sbus_cond_detect.sv
module sbus_cond_detect
    import sbus_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     s_scl,
    input  logic     s_sda,
    output bus_evt_t evt
);
    logic prev_scl;
    logic prev_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b1;
            prev_sda <= 1'b1;
        end else begin
            prev_scl <= s_scl;
            prev_sda <= s_sda;
        end
    end

    always_comb begin
        evt.rel_evt  = s_scl && prev_scl && !prev_sda && s_sda;
        evt.cmd_evt  = s_scl && prev_scl && prev_sda && !s_sda;
        evt.clk_fall = prev_scl && !s_scl;
        evt.clk_lvl  = s_scl;
    end

    assert_evt_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(evt.rel_evt && evt.cmd_evt));
endmodule

// File: rtl/sbus_frame_ack.sv
module sbus_frame_ack
    import sbus_ctl_pkg::*;
#(
    parameter int DATA_BITS = BYTE_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic port_en,
    input  logic xfer_start,
    input  logic clk_fall,
    input  logic clk_lvl,
    input  logic ack_en,
    input  logic ack_en_set,
    input  logic ack_trig_wr,
    output logic ack_drv
);
    localparam int FRAME_BITS = DATA_BITS + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0] cnt;
    ack_state_t       st;
    logic             ack_given;
    logic             byte_done;
    logic             auto_hit;
    logic             late_en;
    logic             manual;

    assign byte_done = (cnt >= DATA_END);
    assign auto_hit  = clk_fall && (cnt == LAST_DATA) && ack_en;
    assign late_en   = ack_en_set && byte_done && !ack_given;
    assign manual    = ack_trig_wr && byte_done;

    always_ff @(posedge clk) begin
        if (rst || !port_en || xfer_start) begin
            cnt       <= '0;
            st        <= ACK_IDLE;
            ack_given <= 1'b0;
        end else begin
            if (clk_fall && cnt != FRAME_END) cnt <= cnt + 1'b1;
            unique case (st)
                ACK_IDLE: if (auto_hit || late_en || manual) st <= ACK_WAIT;
                ACK_WAIT: if (!clk_lvl) begin
                    st        <= ACK_DRIVE;
                    ack_given <= 1'b1;
                end
                ACK_DRIVE: if (clk_fall) st <= ACK_IDLE;
                default: st <= ACK_IDLE;
            endcase
        end
    end

    assign ack_drv = (st == ACK_DRIVE);

    assert_ack_after_byte_R8: assert property (@(posedge clk) disable iff (rst)
        ack_drv |-> (cnt >= DATA_END));
    assert_ack_one_clock_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_drv && clk_fall && port_en && !xfer_start) |=> !ack_drv);
    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> !ack_drv);
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= FRAME_END);
endmodule

// File: rtl/sbus_ctl_unit.sv
module sbus_ctl_unit
    import sbus_ctl_pkg::*;
#(
    parameter int DATA_BITS = BYTE_BITS,
    parameter int SYNC_N    = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [3:0] reg_wdata,
    output logic [3:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       xfer_start,
    input  logic       port_en,
    input  logic       addr_miss,
    output logic       sda_out
);
    ctl_wr_t    wfield;
    ctl_rd_t    rfield;
    bus_evt_t   evt;
    logic [1:0] raw_bus;
    logic [1:0] s_bus;
    logic       so_latch;
    logic       ack_en_q;
    logic       rel_seen;
    logic       cmd_seen;
    logic       ack_drv;
    logic       ack_en_set;

    assign wfield  = ctl_wr_t'(reg_wdata);
    assign raw_bus = {scl_in, sda_in};

    sbus_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_bus),
        .d_out (s_bus)
    );

    sbus_cond_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .s_scl (s_bus[1]),
        .s_sda (s_bus[0]),
        .evt   (evt)
    );

    assign ack_en_set = reg_wr && wfield.ack_en && !ack_en_q;

    sbus_frame_ack #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .port_en     (port_en),
        .xfer_start  (xfer_start),
        .clk_fall    (evt.clk_fall),
        .clk_lvl     (evt.clk_lvl),
        .ack_en      (ack_en_q),
        .ack_en_set  (ack_en_set),
        .ack_trig_wr (reg_wr && wfield.ack_trig),
        .ack_drv     (ack_drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            so_latch <= 1'b1;
            ack_en_q <= 1'b0;
        end else begin
            so_latch <= latch_next(so_latch, reg_wr, wfield);
            if (reg_wr) ack_en_q <= wfield.ack_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !port_en || xfer_start || addr_miss) rel_seen <= 1'b0;
        else if (evt.rel_evt)                          rel_seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !port_en || xfer_start || evt.rel_evt) cmd_seen <= 1'b0;
        else if (evt.cmd_evt)                            cmd_seen <= 1'b1;
    end

    always_comb begin
        rfield.rel_seen = rel_seen;
        rfield.cmd_seen = cmd_seen;
        rfield.zero     = 1'b0;
        rfield.ack_en   = ack_en_q;
    end

    assign reg_rdata = rfield;
    assign sda_out   = ack_drv ? 1'b0 : so_latch;

    assert_rel_trig_high_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wfield.rel_trig) |=> so_latch);
    assert_cmd_trig_low_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wfield.cmd_trig && !wfield.rel_trig) |=> !so_latch);
    assert_rel_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_start || addr_miss || !port_en) |=> !rel_seen);
    assert_cmd_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_start || evt.rel_evt || !port_en) |=> !cmd_seen);
    assert_rel_set_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.rel_evt && port_en && !xfer_start && !addr_miss) |=> rel_seen);
endmodule

// File: tb/sbus_ctl_unit_bench.sv
module sbus_ctl_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       xfer_start = 1'b0;
    logic       port_en = 1'b1;
    logic       addr_miss = 1'b0;
    logic       sda_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sbus_ctl_unit u_sbus_ctl_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_in(scl_in), .sda_in(sda_in),
        .xfer_start(xfer_start), .port_en(port_en), .addr_miss(addr_miss),
        .sda_out(sda_out)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 4'd0;
        wait_cyc(2);
    endtask

    task automatic pulse_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        wait_cyc(2);
    endtask

    task automatic pulse_miss();
        @(negedge clk); addr_miss = 1'b1;
        @(negedge clk); addr_miss = 1'b0;
        wait_cyc(2);
    endtask

    task automatic bus_release();
        scl_in = 1'b0; wait_cyc(6);
        sda_in = 1'b0; wait_cyc(6);
        scl_in = 1'b1; wait_cyc(6);
        sda_in = 1'b1; wait_cyc(6);
    endtask

    task automatic bus_command();
        scl_in = 1'b0; wait_cyc(6);
        sda_in = 1'b1; wait_cyc(6);
        scl_in = 1'b1; wait_cyc(6);
        sda_in = 1'b0; wait_cyc(6);
        scl_in = 1'b0; wait_cyc(6);
        sda_in = 1'b1; wait_cyc(6);
    endtask

    task automatic sclk(output logic mid);
        scl_in = 1'b1; wait_cyc(10);
        mid = sda_out;
        wait_cyc(10);
        scl_in = 1'b0; wait_cyc(20);
    endtask

    task automatic run_clocks(input string tag, input int n, input int low_at);
        logic m;
        for (int i = 1; i <= n; i++) begin
            sclk(m);
            check($sformatf("%s clk%0d", tag, i), {3'd0, m}, (i == low_at) ? 4'd0 : 4'd1);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; wait_cyc(5); rst = 1'b0; wait_cyc(2);
        check("R1 sda_out after reset", {3'd0, sda_out}, 4'd1);
        check("R1 rdata after reset", reg_rdata, 4'd0);
    endtask

    task automatic t_enable_rw();
        reg_write(4'b0001);
        check("R7 enable reads 1", reg_rdata, 4'b0001);
        reg_write(4'b0000);
        check("R7 enable reads 0", reg_rdata, 4'b0000);
    endtask

    task automatic t_triggers();
        reg_write(4'b0100);
        check("R3 command trigger low", {3'd0, sda_out}, 4'd0);
        reg_write(4'b0000);
        check("R3 latch held", {3'd0, sda_out}, 4'd0);
        reg_write(4'b1000);
        check("R2 release trigger high", {3'd0, sda_out}, 4'd1);
        reg_write(4'b0100);
        reg_write(4'b1100);
        check("R2 release wins", {3'd0, sda_out}, 4'd1);
        check("R7 trigger bit reads 0", {3'd0, reg_rdata[1]}, 4'd0);
    endtask

    task automatic t_release_flag();
        bus_release();
        check("R4 release flag set", {3'd0, reg_rdata[3]}, 4'd1);
        pulse_miss();
        check("R5 cleared by addr_miss", {3'd0, reg_rdata[3]}, 4'd0);
        bus_release();
        pulse_start();
        check("R5 cleared by xfer_start", {3'd0, reg_rdata[3]}, 4'd0);
        bus_release();
        port_en = 1'b0; wait_cyc(2);
        check("R5 cleared by port_en 0", {3'd0, reg_rdata[3]}, 4'd0);
        port_en = 1'b1; wait_cyc(2);
    endtask

    task automatic t_command_flag();
        bus_command();
        check("R6 command flag set", {2'd0, reg_rdata[3:2]}, 4'b0001);
        bus_release();
        check("R6 cleared by release", {2'd0, reg_rdata[3:2]}, 4'b0010);
        bus_command();
        pulse_start();
        check("R6 cleared by xfer_start", {3'd0, reg_rdata[2]}, 4'd0);
        bus_command();
        port_en = 1'b0; wait_cyc(2);
        check("R6 cleared by port_en 0", {3'd0, reg_rdata[2]}, 4'd0);
        port_en = 1'b1; wait_cyc(2);
    endtask

    task automatic t_auto_ack();
        reg_write(4'b0001);
        pulse_start();
        run_clocks("R8 auto ack", 9, 9);
        check("R8 latch value back", {3'd0, sda_out}, 4'd1);
    endtask

    task automatic t_no_auto();
        reg_write(4'b0000);
        pulse_start();
        run_clocks("R9 disabled", 9, 0);
    endtask

    task automatic t_late_enable();
        reg_write(4'b0000);
        pulse_start();
        run_clocks("R10 byte", 8, 0);
        reg_write(4'b0001);
        run_clocks("R10 late ack", 2, 1);
    endtask

    task automatic t_manual();
        reg_write(4'b0000);
        pulse_start();
        run_clocks("R11 early", 3, 0);
        reg_write(4'b0010);
        run_clocks("R11 ignored early", 5, 0);
        reg_write(4'b0010);
        run_clocks("R11 manual ack", 2, 1);
    endtask

    task automatic t_disable();
        logic m;
        reg_write(4'b0001);
        pulse_start();
        run_clocks("R12 byte", 8, 0);
        port_en = 1'b0; wait_cyc(3);
        check("R12 ack cancelled", {3'd0, sda_out}, 4'd1);
        sclk(m);
        check("R12 no ack on clk9", {3'd0, m}, 4'd1);
        port_en = 1'b1; wait_cyc(2);
    endtask

    initial begin
        t_reset();
        t_enable_rw();
        t_triggers();
        t_release_flag();
        t_command_flag();
        t_auto_ack();
        t_no_auto();
        t_late_enable();
        t_manual();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule